// File: doc/BRIEF.md
# Sliding-Window 3x3 Convolution Engine

This block computes a valid (unpadded) convolution of one 28x28 single-channel image with one 3x3 kernel and produces a 26x26 feature map. Every pixel, weight and result is a signed 32-bit fixed-point number with 16 fraction bits. The engine performs one multiply-accumulate per clock. It walks the nine kernel taps of a window, writes the window sum into the feature map, and then steps the window to the next position.

An external sequencer places an image and a kernel on the input ports and raises `enable`. It waits for `done`, reads the feature map and then drops `enable`. Dropping `enable` returns the engine to idle, so one instance can be reused for each kernel of a layer in turn. The image and kernel must stay stable while a run is in progress.

Top module: `conv3x3_engine`

## Requirements
- R1: At the end of a run, feature-map element p = r*26 + c (bits [p*32 +: 32] of `fmapFlat`) equals the sum over i, j in 0..2 of the 16-bit-shifted product of image pixel (r+i)*28 + (c+j) (bits [idx*32 +: 32] of `imgFlat`) and kernel weight i*3 + j (bits [idx*32 +: 32] of `kerFlat`).
- R2: Each product is formed exactly at 64 bits and arithmetically shifted right by 16 bits. Its low 32 bits are the term that is added, so a negative product rounds toward minus infinity.
- R3: The accumulation wraps modulo 2^32 and does not saturate.
- R4: Each window sum starts from zero. No part of a previous window's sum appears in the next position.
- R5: `done` first reads high 6085 clock edges after the first edge that samples `enable` high in idle. This is one start cycle plus 9 cycles for each of the 676 positions.
- R6: While `enable` stays high after completion, `done` stays high and `fmapFlat` does not change.
- R7: When `enable` is low while `done` is high, `done` is low after the next edge. The engine stays idle and does not restart until `enable` rises again.
- R8: After reset, `done` is low and every feature-map element is zero.
- R9: If `enable` drops during a run, the engine returns to idle without raising `done`. The next assertion of `enable` starts a complete run from the first position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Starts a run and holds the completed result |
| imgFlat | input | 25088 | 784 image pixels, Q16.16, row-major |
| kerFlat | input | 288 | 9 kernel weights, Q16.16, row-major |
| fmapFlat | output | 21632 | 676 feature-map values, Q16.16, row-major |
| done | output | 1 | Run complete, held until enable drops |

## Verification
The hardest case to reach is an accumulator that wraps past 2^31 in the middle of a window. Random pixels in the normal range of a few units never get there. To reach it, the stimulus includes runs whose pixels and weights are near the top of the integer range, so single products overflow and the partial sums wrap. The same applies to an abort partway through a run followed by a fresh run. The stimulus drops `enable` after a few hundred cycles, then changes the image so that any stale state would show in the next feature map.

// File: rtl/conv3x3_pkg.sv
package conv3x3_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } convState_e;

  // strobes from sequencing logic to the arithmetic
  typedef struct packed {
    logic step;      // one tap is processed this cycle
    logic firstTap;  // restart the window sum
    logic lastTap;   // store the window sum
  } convStrobe_t;

endpackage

// File: rtl/conv3x3_ctrl.sv
module conv3x3_ctrl
  import conv3x3_pkg::*;
#(
  parameter int K_DIM   = 3,
  parameter int OUT_DIM = 26,
  localparam int TW = (K_DIM > 1) ? $clog2(K_DIM) : 1,
  localparam int WW = (OUT_DIM > 1) ? $clog2(OUT_DIM) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  output logic [TW-1:0] tapRow,
  output logic [TW-1:0] tapCol,
  output logic [WW-1:0] winRow,
  output logic [WW-1:0] winCol,
  output convStrobe_t   strb,
  output logic          done
);

  localparam logic [TW-1:0] TAP_LAST = TW'(K_DIM - 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(OUT_DIM - 1);

  convState_e state;

  logic tapEnd, colEnd, rowEnd;
  assign tapEnd = (tapRow == TAP_LAST) && (tapCol == TAP_LAST);
  assign colEnd = (winCol == WIN_LAST);
  assign rowEnd = (winRow == WIN_LAST);

  always_comb begin
    strb.step     = (state == ST_RUN) && enable;
    strb.firstTap = (tapRow == '0) && (tapCol == '0);
    strb.lastTap  = tapEnd;
  end

  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tapRow <= '0;
      tapCol <= '0;
      winRow <= '0;
      winCol <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tapRow <= '0;
          tapCol <= '0;
          winRow <= '0;
          winCol <= '0;
          if (enable) state <= ST_RUN;
        end
        ST_RUN: begin
          if (!enable) begin
            state  <= ST_IDLE;
            tapRow <= '0;
            tapCol <= '0;
            winRow <= '0;
            winCol <= '0;
          end else if (tapCol != TAP_LAST) begin
            tapCol <= tapCol + 1'b1;
          end else if (tapRow != TAP_LAST) begin
            tapCol <= '0;
            tapRow <= tapRow + 1'b1;
          end else begin
            tapCol <= '0;
            tapRow <= '0;
            if (!colEnd) begin
              winCol <= winCol + 1'b1;
            end else begin
              winCol <= '0;
              if (!rowEnd) begin
                winRow <= winRow + 1'b1;
              end else begin
                winRow <= '0;
                state  <= ST_DONE;
              end
            end
          end
        end
        ST_DONE: begin
          if (!enable) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/conv3x3_dp.sv
module conv3x3_dp
  import conv3x3_pkg::*;
#(
  parameter int IMG_DIM = 28,
  parameter int K_DIM   = 3,
  parameter int DATA_W  = 32,
  parameter int FRAC_W  = 16,
  localparam int OUT_DIM = IMG_DIM - K_DIM + 1,
  localparam int TW = (K_DIM > 1) ? $clog2(K_DIM) : 1,
  localparam int WW = (OUT_DIM > 1) ? $clog2(OUT_DIM) : 1,
  localparam int IMG_BITS = IMG_DIM * IMG_DIM * DATA_W,
  localparam int KER_BITS = K_DIM * K_DIM * DATA_W,
  localparam int MAP_BITS = OUT_DIM * OUT_DIM * DATA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [IMG_BITS-1:0] imgFlat,
  input  logic [KER_BITS-1:0] kerFlat,
  input  logic [TW-1:0]       tapRow,
  input  logic [TW-1:0]       tapCol,
  input  logic [WW-1:0]       winRow,
  input  logic [WW-1:0]       winCol,
  input  convStrobe_t         strb,
  output logic [MAP_BITS-1:0] fmapFlat
);

  localparam int PROD_W = 2 * DATA_W;

  int pixIdx, wgtIdx, outIdx;
  logic signed [DATA_W-1:0] pix, wgt, term, acc, sum;
  logic signed [PROD_W-1:0] prod, scaled;

  always_comb begin
    pixIdx = (int'(winRow) + int'(tapRow)) * IMG_DIM + int'(winCol) + int'(tapCol);
    wgtIdx = int'(tapRow) * K_DIM + int'(tapCol);
    outIdx = int'(winRow) * OUT_DIM + int'(winCol);
    pix    = imgFlat[pixIdx*DATA_W +: DATA_W];
    wgt    = kerFlat[wgtIdx*DATA_W +: DATA_W];
    prod   = PROD_W'(pix) * PROD_W'(wgt);
    scaled = prod >>> FRAC_W;
    term   = scaled[DATA_W-1:0];
    sum    = (strb.firstTap ? '0 : acc) + term;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      fmapFlat <= '0;
    end else if (strb.step) begin
      acc <= sum;
      if (strb.lastTap) fmapFlat[outIdx*DATA_W +: DATA_W] <= sum;
    end
  end

endmodule

// File: rtl/conv3x3_engine.sv
module conv3x3_engine
  import conv3x3_pkg::*;
#(
  parameter int IMG_DIM = 28,
  parameter int K_DIM   = 3,
  parameter int DATA_W  = 32,
  parameter int FRAC_W  = 16,
  localparam int OUT_DIM  = IMG_DIM - K_DIM + 1,
  localparam int IMG_BITS = IMG_DIM * IMG_DIM * DATA_W,
  localparam int KER_BITS = K_DIM * K_DIM * DATA_W,
  localparam int MAP_BITS = OUT_DIM * OUT_DIM * DATA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [IMG_BITS-1:0] imgFlat,
  input  logic [KER_BITS-1:0] kerFlat,
  output logic [MAP_BITS-1:0] fmapFlat,
  output logic                done
);

  localparam int TW = (K_DIM > 1) ? $clog2(K_DIM) : 1;
  localparam int WW = (OUT_DIM > 1) ? $clog2(OUT_DIM) : 1;

  logic [TW-1:0] tapRow, tapCol;
  logic [WW-1:0] winRow, winCol;
  convStrobe_t   strb;

  conv3x3_ctrl #(.K_DIM(K_DIM), .OUT_DIM(OUT_DIM)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .tapRow(tapRow), .tapCol(tapCol), .winRow(winRow), .winCol(winCol),
    .strb(strb), .done(done)
  );

  conv3x3_dp #(.IMG_DIM(IMG_DIM), .K_DIM(K_DIM), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .imgFlat(imgFlat), .kerFlat(kerFlat),
    .tapRow(tapRow), .tapCol(tapCol), .winRow(winRow), .winCol(winCol),
    .strb(strb), .fmapFlat(fmapFlat)
  );

endmodule

// File: rtl/conv3x3_chk.sv
module conv3x3_chk #(
  parameter int MAP_BITS = 21632
) (
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic [MAP_BITS-1:0] fmapFlat,
  input logic                done
);

  // R6
  hold_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && enable) |=> done);

  // R6
  map_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && enable) |=> $stable(fmapFlat));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !enable) |=> !done);

  // R9
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !done) |=> !done);

  // R5
  done_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(enable));

endmodule

bind conv3x3_engine conv3x3_chk #(.MAP_BITS(MAP_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .fmapFlat(fmapFlat), .done(done)
);

// File: tb/sim_conv3x3_engine.sv
`timescale 1ns/1ps
module sim_conv3x3_engine;

  localparam int IMG = 28;
  localparam int OD  = 26;
  localparam int RUN_CYCLES = 1 + 9 * OD * OD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [IMG*IMG*32-1:0] img = '0;
  logic [9*32-1:0] ker = '0;
  logic [OD*OD*32-1:0] fmap;
  logic done;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  conv3x3_engine u0 (
    .clk(clk), .rstN(rstN), .enable(enable),
    .imgFlat(img), .kerFlat(ker), .fmapFlat(fmap), .done(done)
  );

  function automatic int expOut(int r, int c);
    int acc = 0;
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        longint p;
        p = longint'($signed(img[((r+i)*IMG + c + j)*32 +: 32])) *
            longint'($signed(ker[(i*3 + j)*32 +: 32]));
        acc = acc + int'(p >>> 16);
      end
    end
    return acc;
  endfunction

  task automatic note(bit ok, string req, longint got, longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic checkMap(string req);
    for (int p = 0; p < OD*OD; p++) begin
      int g, e;
      g = $signed(fmap[p*32 +: 32]);
      e = expOut(p / OD, p % OD);
      note(g == e, req, g, e);
    end
  endtask

  // start a run from idle and measure the latency to done (R5)
  task automatic runFull(string req);
    int n = 0;
    @(negedge clk);
    enable = 1'b1;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!done && n < RUN_CYCLES + 50);
    note(n == RUN_CYCLES, "R5 latency", n, RUN_CYCLES);
    checkMap(req);
  endtask

  task automatic release_();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    note(done == 1'b0, "R7 done drop", done, 0);
  endtask

  function automatic int smallQ();
    return int'($urandom % 32'h0010_0000) - 32'sh0008_0000;
  endfunction

  task automatic fillRandom();
    for (int p = 0; p < IMG*IMG; p++) img[p*32 +: 32] = smallQ();
    for (int k = 0; k < 9; k++) ker[k*32 +: 32] = smallQ();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      misses++;
      vectors++;
      $display("FAIL watchdog got=%0d expected=<190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_2468));
    repeat (3) @(negedge clk);
    // R8 reset state
    note(done == 1'b0, "R8 done", done, 0);
    note(fmap == '0, "R8 fmap zero", (fmap == '0) ? 0 : 1, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 random run
    fillRandom();
    runFull("R1 random");

    // R6 hold with enable high
    repeat (20) @(negedge clk);
    note(done == 1'b1, "R6 done held", done, 1);
    checkMap("R6 map held");

    // R7 release and stay idle
    release_();
    repeat (10) @(negedge clk);
    note(done == 1'b0, "R7 stays idle", done, 0);

    // R2 negative products: negative kernel, mixed image with odd fractions
    for (int p = 0; p < IMG*IMG; p++) img[p*32 +: 32] = int'($urandom % 32'h0004_0000) - 32'sh0002_0000 + 1;
    for (int k = 0; k < 9; k++) ker[k*32 +: 32] = -(int'($urandom % 32'h0003_0000) + 3);
    runFull("R2 negative rounding");
    release_();

    // R3 wraparound with very large operands
    for (int p = 0; p < IMG*IMG; p++) img[p*32 +: 32] = 32'sh7000_0000 + int'($urandom % 32'h0FFF_FFFF);
    for (int k = 0; k < 9; k++) ker[k*32 +: 32] = (k % 2 == 0) ? 32'sh7FFF_0000 : 32'sh6123_4567;
    runFull("R3 wrap");
    release_();

    // R4 large block beside zeros: no leakage between windows
    for (int p = 0; p < IMG*IMG; p++) img[p*32 +: 32] = ((p % IMG) < 14) ? 32'sh0100_0000 : 32'sh0;
    for (int k = 0; k < 9; k++) ker[k*32 +: 32] = 32'sh0001_0000;
    runFull("R4 window clear");
    release_();

    // R9 abort mid-run, then full run on new data
    fillRandom();
    @(negedge clk);
    enable = 1'b1;
    repeat (300) @(negedge clk);
    enable = 1'b0;
    repeat (5) @(negedge clk);
    note(done == 1'b0, "R9 abort no done", done, 0);
    fillRandom();
    runFull("R9 rerun");
    release_();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule